// File: doc/BRIEF.md
# Deserialized pulse width averager

This block measures short, asynchronous high pulses that a 10:1 receive deserializer has already oversampled. Each core clock delivers one 10-bit sample word, in which bit 0 is the oldest sample. At 740 Mb/s one sample stands for about 1.35 ns, so pulses of 10 ns to 150 ns cover roughly 7 to 111 samples. Pulses repeat at 1 Hz to 70 kHz and nothing announces them, so the block watches every valid word.

The block keeps the last sample of the previous valid word. It can therefore find a rising or falling transition at any bit position, including one that falls exactly on a word boundary. It reports the width of each pulse in samples. It also adds up ten reported widths in a row and presents the total together with that total divided by ten, which gives a finer figure than any single width.

The measurement controller has three states:
- **IDLE**: the line is low.
- **HIGH**: a pulse is being counted.
- **OVER**: the pulse has run too long and is being discarded.

The transitions are:
- **IDLE to IDLE**, with a report: the rise and the fall are in the same word.
- **IDLE to HIGH**: a rise is seen and no fall follows it in the same word.
- **HIGH to HIGH**: a whole high word is added to the count.
- **HIGH to IDLE**, with a report: a fall is seen and the width is within the limit.
- **HIGH to IDLE**, with overflow: a fall is seen and the width is over the limit.
- **HIGH to OVER**: the count passes the limit before any fall is seen.
- **OVER to IDLE**: a fall is seen.

Top module: `pwavg_top`

## Requirements
- R1: A synchronous reset clears the stored previous sample, the controller state, the ten-pulse counter and the accumulator. While reset is held and right after it, every output is 0.
- R2: The reported width is the number of high samples from the rising-transition bit up to, but not including, the falling-transition bit. Bit 0 of a word is the earliest sample. `width_o` is updated and `width_vld_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the word containing the falling bit.
- R3: A pulse that starts and ends inside one word is measured correctly, down to a width of one sample.
- R4: A transition between the last bit of one valid word and bit 0 of the next valid word is detected as a rise or a fall at bit position 0.
- R5: A pulse that spans any number of words is measured correctly, for widths up to 255 samples.
- R6: A word presented with `word_vld_i` low is ignored. It detects no transition and changes neither the stored previous sample nor the count.
- R7: A pulse longer than 255 samples gives no width report. `ovf_o` is 1 by the cycle after the word containing its fall. `ovf_o` returns to 0 in the same cycle as the next width report.
- R8: After every tenth width report since reset, or since the previous total, `sum_o` holds the sum of those ten widths. `sum_vld_o` is high for one cycle, in the cycle after the tenth `width_vld_o`, and the count then starts again.
- R9: `avg_o` equals `sum_o` divided by ten, rounded down, and it is valid in the same cycle as `sum_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | 10 | Sample word, bit 0 earliest |
| word_vld_i | input | 1 | Sample word qualifier |
| width_o | output | 8 | Last single-pulse width in samples |
| width_vld_o | output | 1 | One-cycle strobe for `width_o` |
| sum_o | output | 12 | Total of the last ten widths |
| avg_o | output | 8 | `sum_o` divided by ten, rounded down |
| sum_vld_o | output | 1 | One-cycle strobe for `sum_o` and `avg_o` |
| ovf_o | output | 1 | Last pulse exceeded the width limit |

## Verification
Two events can land in the same word:
- A pulse's rise and its fall. Both are found in one cycle, and the width comes from their two bit positions.
- A width report and the clearing of `ovf_o`. Both happen in the same cycle.

The bench provokes the first case by sweeping every start offset against short widths, including single-sample pulses and falls on bit 9 or bit 0. It provokes the second case by sending a valid pulse directly after each over-length pulse. It judges the result by comparing, in the exact cycle after the falling word, the reported width and the overflow flag against a sample-by-sample model of the line.

// File: rtl/pwavg_pkg.sv
package pwavg_pkg;

    localparam int unsigned DEF_WORD_W = 10;
    localparam int unsigned DEF_MAXW   = 255;
    localparam int unsigned DEF_NAVG   = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_OVER
    } meas_state_t;

endpackage

// File: rtl/pwavg_edge.sv
module pwavg_edge #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned POS_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              rise_any_o,
    output logic [POS_W-1:0]  rise_pos_o,
    output logic              fall_any_o,
    output logic [POS_W-1:0]  fall_pos_o
);

    logic              prev_q;
    logic [WORD_W:0]   ext;
    logic [WORD_W-1:0] rise_vec;
    logic [WORD_W-1:0] fall_vec;

    assign ext = {word_i, prev_q};

    // Keep the last sample of the last accepted word.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else if (valid_i) begin
            prev_q <= word_i[WORD_W-1];
        end
    end

    for (genvar g = 0; g < WORD_W; g++) begin : g_bit
        assign rise_vec[g] = ext[g+1] & ~ext[g];
        assign fall_vec[g] = ~ext[g+1] & ext[g];
    end

    // Lowest bit position wins.
    always_comb begin
        rise_pos_o = '0;
        fall_pos_o = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (rise_vec[i]) rise_pos_o = POS_W'(i);
            if (fall_vec[i]) fall_pos_o = POS_W'(i);
        end
    end

    assign rise_any_o = |rise_vec;
    assign fall_any_o = |fall_vec;

endmodule

// File: rtl/pwavg_meas.sv
module pwavg_meas
    import pwavg_pkg::*;
#(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned MAXW   = 255,
    parameter int unsigned POS_W  = 4,
    parameter int unsigned WID_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic             rise_any_i,
    input  logic [POS_W-1:0] rise_pos_i,
    input  logic             fall_any_i,
    input  logic [POS_W-1:0] fall_pos_i,
    output logic [WID_W-1:0] width_o,
    output logic             width_vld_o,
    output logic             ovf_o
);

    localparam int unsigned CNT_W = $clog2(MAXW + WORD_W + 1);
    localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] MAXW_C = CNT_W'(MAXW);

    meas_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             emit, set_ovf;
    logic [CNT_W-1:0] emit_w;
    logic [CNT_W-1:0] span_w, head_w, tail_w, grow_w;

    assign span_w = CNT_W'(fall_pos_i) - CNT_W'(rise_pos_i);
    assign head_w = WORD_C - CNT_W'(rise_pos_i);
    assign tail_w = cnt_q + CNT_W'(fall_pos_i);
    assign grow_w = cnt_q + WORD_C;

    // Next state and count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        emit    = 1'b0;
        set_ovf = 1'b0;
        emit_w  = '0;
        if (valid_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rise_any_i) begin
                        if (fall_any_i) begin
                            emit   = 1'b1;
                            emit_w = span_w;
                        end else begin
                            state_d = ST_HIGH;
                            cnt_d   = head_w;
                        end
                    end
                end
                ST_HIGH: begin
                    if (fall_any_i) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                        if (tail_w > MAXW_C) begin
                            set_ovf = 1'b1;
                        end else begin
                            emit   = 1'b1;
                            emit_w = tail_w;
                        end
                    end else if (grow_w > MAXW_C) begin
                        state_d = ST_OVER;
                        cnt_d   = '0;
                        set_ovf = 1'b1;
                    end else begin
                        cnt_d = grow_w;
                    end
                end
                ST_OVER: begin
                    if (fall_any_i) state_d = ST_IDLE;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            width_o     <= '0;
            width_vld_o <= 1'b0;
            ovf_o       <= 1'b0;
        end else begin
            width_vld_o <= emit;
            if (emit) begin
                width_o <= WID_W'(emit_w);
                ovf_o   <= 1'b0;
            end else if (set_ovf) begin
                ovf_o <= 1'b1;
            end
        end
    end

    AST_WIDTH_NONZERO: assert property (@(posedge clk) disable iff (rst)
        width_vld_o |-> (width_o != '0)); // R2
    AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        width_vld_o |-> !ovf_o); // R7
    AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(valid_i) |-> ($stable(state_q) && $stable(cnt_q))); // R6
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(valid_i) |-> !width_vld_o); // R6

endmodule

// File: rtl/pwavg_acc.sv
module pwavg_acc #(
    parameter int unsigned WID_W = 8,
    parameter int unsigned NAVG  = 10,
    parameter int unsigned SUM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WID_W-1:0] width_i,
    input  logic             width_vld_i,
    output logic [SUM_W-1:0] sum_o,
    output logic [WID_W-1:0] avg_o,
    output logic             sum_vld_o
);

    localparam int unsigned IDX_W = $clog2(NAVG);
    localparam logic [IDX_W-1:0] LAST_C = IDX_W'(NAVG - 1);

    logic [IDX_W-1:0] idx_q;
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] acc_next;

    assign acc_next = acc_q + SUM_W'(width_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            acc_q     <= '0;
            sum_o     <= '0;
            sum_vld_o <= 1'b0;
        end else begin
            sum_vld_o <= 1'b0;
            if (width_vld_i) begin
                if (idx_q == LAST_C) begin
                    sum_o     <= acc_next;
                    sum_vld_o <= 1'b1;
                    acc_q     <= '0;
                    idx_q     <= '0;
                end else begin
                    acc_q <= acc_next;
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign avg_o = WID_W'(sum_o / SUM_W'(NAVG));

    AST_SUM_AFTER_WIDTH: assert property (@(posedge clk) disable iff (rst)
        sum_vld_o |-> $past(width_vld_i)); // R8
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST_C); // R8
    AST_AVG_FLOOR: assert property (@(posedge clk) disable iff (rst)
        sum_vld_o |-> ((SUM_W'(avg_o) * SUM_W'(NAVG)) <= sum_o)); // R9

endmodule

// File: rtl/pwavg_top.sv
module pwavg_top
    import pwavg_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned MAXW   = DEF_MAXW,
    parameter int unsigned NAVG   = DEF_NAVG,
    localparam int unsigned POS_W = $clog2(WORD_W),
    localparam int unsigned WID_W = $clog2(MAXW + 1),
    localparam int unsigned SUM_W = $clog2(MAXW * NAVG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_vld_i,
    output logic [WID_W-1:0]  width_o,
    output logic              width_vld_o,
    output logic [SUM_W-1:0]  sum_o,
    output logic [WID_W-1:0]  avg_o,
    output logic              sum_vld_o,
    output logic              ovf_o
);

    logic             rise_any, fall_any;
    logic [POS_W-1:0] rise_pos, fall_pos;

    pwavg_edge #(.WORD_W(WORD_W), .POS_W(POS_W)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (word_vld_i),
        .word_i     (word_i),
        .rise_any_o (rise_any),
        .rise_pos_o (rise_pos),
        .fall_any_o (fall_any),
        .fall_pos_o (fall_pos)
    );

    pwavg_meas #(.WORD_W(WORD_W), .MAXW(MAXW), .POS_W(POS_W), .WID_W(WID_W)) u_meas (
        .clk         (clk),
        .rst         (rst),
        .valid_i     (word_vld_i),
        .rise_any_i  (rise_any),
        .rise_pos_i  (rise_pos),
        .fall_any_i  (fall_any),
        .fall_pos_i  (fall_pos),
        .width_o     (width_o),
        .width_vld_o (width_vld_o),
        .ovf_o       (ovf_o)
    );

    pwavg_acc #(.WID_W(WID_W), .NAVG(NAVG), .SUM_W(SUM_W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .width_i     (width_o),
        .width_vld_i (width_vld_o),
        .sum_o       (sum_o),
        .avg_o       (avg_o),
        .sum_vld_o   (sum_vld_o)
    );

endmodule

// File: tb/pwavg_top_test.sv
module pwavg_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  word_i;
    logic        word_vld_i;
    logic [7:0]  width_o;
    logic        width_vld_o;
    logic [11:0] sum_o;
    logic [7:0]  avg_o;
    logic        sum_vld_o;
    logic        ovf_o;

    pwavg_top uut (
        .clk(clk), .rst(rst), .word_i(word_i), .word_vld_i(word_vld_i),
        .width_o(width_o), .width_vld_o(width_vld_o), .sum_o(sum_o),
        .avg_o(avg_o), .sum_vld_o(sum_vld_o), .ovf_o(ovf_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // Line model.
    logic [9:0] buf_w;
    int    fill = 0;
    int    run = 0;
    logic  lastb = 1'b0;
    int    m_n = 0;
    int    m_acc = 0;
    string tag = "R2";
    bit    inj = 0;
    int    wcnt = 0;

    // Word under assembly.
    bit cur_wv, cur_done, cur_ovf, cur_tenth;
    int cur_w, cur_sum;
    // One cycle after the word.
    bit s1_wv, s1_done, s1_ovf, s1_tenth;
    int s1_w, s1_sum;
    string s1_tag;
    // Two cycles after the word.
    bit s2_sv;
    int s2_sum;

    task automatic chk(input string t, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    task automatic check_outs();
        chk({s1_tag, " width strobe"}, int'(width_vld_o), int'(s1_wv));
        if (s1_wv) chk({s1_tag, " width value"}, int'(width_o), s1_w);
        if (s1_done) chk("R7 overflow flag", int'(ovf_o), int'(s1_ovf));
        chk("R8 sum strobe", int'(sum_vld_o), int'(s2_sv));
        if (s2_sv) begin
            chk("R8 sum value", int'(sum_o), s2_sum);
            chk("R9 average value", int'(avg_o), s2_sum / 10);
        end
    endtask

    task automatic clear_pipe();
        cur_wv = 0; cur_done = 0; cur_ovf = 0; cur_tenth = 0; cur_w = 0; cur_sum = 0;
        s1_wv = 0; s1_done = 0; s1_ovf = 0; s1_tenth = 0; s1_w = 0; s1_sum = 0;
        s1_tag = "R1";
        s2_sv = 0; s2_sum = 0;
    endtask

    task automatic send_word(input bit v);
        @(negedge clk);
        check_outs();
        word_i     = v ? buf_w : {10{~lastb}};
        word_vld_i = v;
        s2_sv  = s1_tenth;
        s2_sum = s1_sum;
        if (v) begin
            s1_wv = cur_wv; s1_done = cur_done; s1_ovf = cur_ovf;
            s1_tenth = cur_tenth; s1_w = cur_w; s1_sum = cur_sum; s1_tag = tag;
            cur_wv = 0; cur_done = 0; cur_ovf = 0; cur_tenth = 0; cur_w = 0; cur_sum = 0;
            fill = 0;
        end else begin
            s1_wv = 0; s1_done = 0; s1_ovf = 0; s1_tenth = 0; s1_w = 0; s1_sum = 0;
            s1_tag = "R6";
        end
    endtask

    task automatic emit_bit(input logic b);
        if (b) begin
            run++;
        end else if (lastb) begin
            cur_done = 1;
            if (run <= 255) begin
                cur_wv = 1; cur_w = run; cur_ovf = 0;
                m_acc += run; m_n++;
                if (m_n == 10) begin
                    cur_tenth = 1; cur_sum = m_acc; m_n = 0; m_acc = 0;
                end
            end else begin
                cur_ovf = 1;
            end
            run = 0;
        end
        lastb = b;
        buf_w[fill] = b;
        fill++;
        if (fill == 10) begin
            send_word(1);
            wcnt++;
            if (inj && (wcnt % 3 == 0)) send_word(0);
        end
    endtask

    // Low gap long enough that no word holds a fall and a later rise.
    task automatic pulse(input int off, input int w);
        for (int i = 0; i < 12; i++) emit_bit(1'b0);
        while (fill != off) emit_bit(1'b0);
        for (int i = 0; i < w; i++) emit_bit(1'b1);
    endtask

    task automatic drain();
        for (int i = 0; i < 12; i++) emit_bit(1'b0);
        while (fill != 0) emit_bit(1'b0);
        send_word(0);
        send_word(0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        word_vld_i = 1'b0;
        word_i = '0;
        repeat (3) @(negedge clk);
        chk("R1 width strobe in reset", int'(width_vld_o), 0);
        chk("R1 sum strobe in reset", int'(sum_vld_o), 0);
        chk("R1 overflow in reset", int'(ovf_o), 0);
        chk("R1 sum in reset", int'(sum_o), 0);
        chk("R1 width in reset", int'(width_o), 0);
        rst = 1'b0;
        run = 0; lastb = 1'b0; fill = 0; m_n = 0; m_acc = 0;
        clear_pipe();
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_pipe();
        do_reset();

        // Short widths against every start offset.
        for (int w = 1; w <= 24; w++) begin
            for (int off = 0; off < 10; off++) begin
                if (off + w < 10)                        tag = "R3";
                else if (off == 0 || (off + w) % 10 == 0) tag = "R4";
                else                                     tag = "R5";
                inj = (off % 2 == 1);
                pulse(off, w);
            end
        end
        inj = 1;

        // Long widths up to the limit.
        tag = "R5";
        for (int w = 90; w <= 130; w++) pulse(w % 10, w);
        for (int w = 250; w <= 255; w++) begin
            for (int off = 0; off < 10; off++) pulse(off, w);
        end

        // Over-length pulses, each followed by a valid one.
        tag = "R7";
        pulse(0, 256); pulse(3, 20);
        pulse(9, 257); pulse(5, 7);
        pulse(4, 300); pulse(0, 255);
        pulse(1, 600); pulse(8, 1);
        drain();

        // Reset in the middle of a ten-pulse group.
        tag = "R1";
        pulse(2, 30); pulse(5, 40); pulse(7, 50);
        drain();
        do_reset();
        for (int w = 7; w <= 16; w++) pulse(w % 10, w);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule